// File: doc/BRIEF.md
# Diagonal Cacheline Interleave Read Pipeline

This block holds one subarray of eight racetrack storage units. Each unit has 64 rows and each row holds one 8-byte word. A 64-byte cacheline is cut into eight 8-byte parts. The parts are placed on a diagonal: each part of a line goes to a different unit, and all of them sit at the same row. Because of this placement, every beat of a line comes from a different unit. While one unit drives the current beat, the unit that serves the next beat is already moving its track into place.

A caller gives a line index and pulses a start strobe. The block then returns the line as eight back-to-back 64-bit beats under a valid flag, in the same pattern as a burst of length 8. It drives one shift enable per unit, and it reports the row that each unit's access port currently faces. A separate write port stores one part at a time, using the same diagonal mapping, so the subarray can be filled. While a line is streaming, a busy flag is raised and any start request is ignored.

Top module: `diag_line_reader`

## Requirements
- R1: After reset, busy_o, beat_valid_o and every bit of unit_en_o are 0, and each unit's port faces row 0.
- R2: A start_i pulse seen while busy_o is 0 raises busy_o at the next edge. Beat 0 is valid one cycle after that. Eight valid beats then follow with no gap, and beat_valid_o is 0 in the cycle after the eighth beat.
- R3: Beat k of line c carries the 64-bit word written as part k of line c, and beats leave in part order 0 to 7.
- R4: Part p of line c is held in unit (c + p) mod 8 at row c. Bit u of unit_en_o drives unit u, and unit u's row sits at unit_row_o[6u+5:6u].
- R5: Unit enables follow a fixed order, one step ahead of the beats:
  - In the cycle a start is accepted, only unit c mod 8 is enabled.
  - In streaming phase p, for p from 0 to 6, only unit (c + p + 1) mod 8 is enabled.
  - In phase 7, no unit is enabled.
- R6: At most one bit of unit_en_o is set in any cycle. An enabled unit faces the requested row at the next cycle.
- R7: busy_o stays high for exactly eight cycles, one for each phase. It falls in the same cycle that the eighth beat is presented.
- R8: A start_i pulse seen while busy_o is 1 is ignored. The line in flight is not changed, and no further burst follows it.
- R9: A start_i pulse in the cycle that carries the eighth beat is accepted. The next line's beat 0 then appears two cycles later.
- R10: The write port stores wr_data_i as part wr_part_i of line wr_line_i, using the R4 mapping. Line indices 56 to 63 wrap around the unit numbers in the same way as every other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to stream one line |
| line_i | input | 6 | Index of the line to stream |
| wr_en_i | input | 1 | Write one part |
| wr_line_i | input | 6 | Line index for the write |
| wr_part_i | input | 3 | Part index for the write |
| wr_data_i | input | 64 | Part data to write |
| busy_o | output | 1 | High while a line is streaming |
| beat_valid_o | output | 1 | Beat data is valid |
| beat_data_o | output | 64 | Beat data |
| unit_en_o | output | 8 | Per-unit shift enable |
| unit_row_o | output | 48 | Per-unit row the port faces, 6 bits per unit |

## Verification
The bench fills all 64 lines with a pattern that is unique to each line and part. It then streams lines whose diagonal wraps past unit 7, such as lines 5 and 63. A design that got the modulo placement wrong would return parts of the wrong line, or the wrong part. The bench checks every unit enable and every row phase by phase, so a missing or late lookahead shows up as a wrong enable or a stale row, not just as bad data. It also injects a start in the middle of a burst, which a design that does not ignore it would answer by retargeting or repeating the burst. Finally it chains a second line onto the last beat, which exposes any extra dead cycle, or a refused start, at the hand-over.

// File: rtl/diag_pkg.sv
package diag_pkg;
  // Unit that holds part p of line c.
  function automatic int unsigned diag_unit(int unsigned line, int unsigned part, int unsigned n);
    return (line + part) % n;
  endfunction
endpackage

// File: rtl/rt_unit.sv
module rt_unit #(
  parameter int ROWS = 64,
  parameter int PW   = 64,
  localparam int LW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sh_en_i,
  input  logic [LW-1:0] sh_row_i,
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_row_i,
  input  logic [PW-1:0] wr_data_i,
  output logic [LW-1:0] pos_o,
  output logic [PW-1:0] rd_data_o
);
  logic [PW-1:0] mem [ROWS];
  logic [LW-1:0] pos_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_row_i] <= wr_data_i;
  end

  // A shift completes within one beat.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (sh_en_i) pos_q <= sh_row_i;
  end

  assign pos_o     = pos_q;
  assign rd_data_o = mem[pos_q];

  // R6
  shift_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_en_i |=> pos_q == $past(sh_row_i));
endmodule

// File: rtl/diag_seq.sv
module diag_seq #(
  parameter int N  = 8,
  parameter int LW = 6,
  parameter int PW = 64,
  localparam int UW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] line_i,
  input  logic [PW-1:0] rd_data_i,
  output logic          busy_o,
  output logic [LW-1:0] line_o,
  output logic [UW-1:0] rd_unit_o,
  output logic          sh_en_o,
  output logic [UW-1:0] sh_unit_o,
  output logic [LW-1:0] sh_row_o,
  output logic          beat_valid_o,
  output logic [PW-1:0] beat_data_o
);
  logic          busy_q, vld_q;
  logic [UW-1:0] phase_q, part_q;
  logic [LW-1:0] line_q;
  logic [PW-1:0] data_q;
  logic          accept, last;

  assign accept = start_i & ~busy_q;
  assign last   = phase_q == UW'(N-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      line_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      phase_q <= '0;
      line_q  <= line_i;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      phase_q <= phase_q + UW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      part_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= busy_q;
      if (busy_q) begin
        part_q <= phase_q;
        data_q <= rd_data_i;
      end
    end
  end

  // Lookahead: align the unit of the next part while this one is read.
  assign rd_unit_o = line_q[UW-1:0] + phase_q;
  assign sh_en_o   = accept | (busy_q & ~last);
  assign sh_unit_o = accept ? line_i[UW-1:0] : line_q[UW-1:0] + phase_q + UW'(1);
  assign sh_row_o  = accept ? line_i : line_q;

  assign busy_o       = busy_q;
  assign line_o       = line_q;
  assign beat_valid_o = vld_q;
  assign beat_data_o  = data_q;

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && phase_q == '0);
  // R2
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && part_q != UW'(N-1) |=> vld_q && part_q == $past(part_q) + UW'(1));
  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && last |=> !busy_q);
  // R8
  hold_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> $stable(line_q));
endmodule

// File: rtl/diag_line_reader.sv
module diag_line_reader #(
  parameter int N    = 8,
  parameter int ROWS = 64,
  parameter int PW   = 64,
  localparam int LW  = $clog2(ROWS),
  localparam int UW  = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LW-1:0]   line_i,
  input  logic            wr_en_i,
  input  logic [LW-1:0]   wr_line_i,
  input  logic [UW-1:0]   wr_part_i,
  input  logic [PW-1:0]   wr_data_i,
  output logic            busy_o,
  output logic            beat_valid_o,
  output logic [PW-1:0]   beat_data_o,
  output logic [N-1:0]    unit_en_o,
  output logic [N*LW-1:0] unit_row_o
);
  import diag_pkg::*;

  logic [PW-1:0] unit_dout [N];
  logic [LW-1:0] unit_pos  [N];
  logic [LW-1:0] cur_line, sh_row;
  logic [UW-1:0] rd_unit, sh_unit, wr_unit;
  logic          sh_en;

  assign wr_unit = UW'(diag_unit(int'(wr_line_i), int'(wr_part_i), N));

  diag_seq #(.N(N), .LW(LW), .PW(PW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .line_i      (line_i),
    .rd_data_i   (unit_dout[rd_unit]),
    .busy_o      (busy_o),
    .line_o      (cur_line),
    .rd_unit_o   (rd_unit),
    .sh_en_o     (sh_en),
    .sh_unit_o   (sh_unit),
    .sh_row_o    (sh_row),
    .beat_valid_o(beat_valid_o),
    .beat_data_o (beat_data_o)
  );

  for (genvar u = 0; u < N; u++) begin : g_unit
    assign unit_en_o[u] = sh_en && sh_unit == UW'(u);
    assign unit_row_o[u*LW +: LW] = unit_pos[u];

    rt_unit #(.ROWS(ROWS), .PW(PW)) u_rt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sh_en_i  (unit_en_o[u]),
      .sh_row_i (sh_row),
      .wr_en_i  (wr_en_i && wr_unit == UW'(u)),
      .wr_row_i (wr_line_i),
      .wr_data_i(wr_data_i),
      .pos_o    (unit_pos[u]),
      .rd_data_o(unit_dout[u])
    );
  end

  // R6
  one_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(unit_en_o));
  // R4
  aligned_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> unit_pos[rd_unit] == cur_line);
endmodule

// File: tb/sim_diag_line_reader.sv
module sim_diag_line_reader;
  localparam int N = 8, ROWS = 64, PW = 64, LW = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, wr_en_i = 1'b0;
  logic [LW-1:0] line_i = '0, wr_line_i = '0;
  logic [2:0] wr_part_i = '0;
  logic [PW-1:0] wr_data_i = '0;
  logic busy_o, beat_valid_o;
  logic [PW-1:0] beat_data_o;
  logic [N-1:0] unit_en_o;
  logic [N*LW-1:0] unit_row_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  diag_line_reader u0 (.*);

  function automatic logic [PW-1:0] pat(int c, int p);
    return {8'(8'hD0 | p), 8'(c), 16'(16'hBEEF ^ (c * p)), 32'(c * 131 + p * 7 + 1)};
  endfunction

  task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk(busy_o == 0 && beat_valid_o == 0, "R1 busy/valid", {busy_o, beat_valid_o}, 0);
    chk(unit_en_o == 0, "R1 enables", unit_en_o, 0);
    chk(unit_row_o == 0, "R1 rows", unit_row_o, 0);
  endtask

  task automatic fill();
    for (int c = 0; c < ROWS; c++)
      for (int p = 0; p < N; p++) begin
        wr_en_i = 1; wr_line_i = LW'(c); wr_part_i = 3'(p); wr_data_i = pat(c, p);
        @(negedge clk_i);
      end
    wr_en_i = 0;
  endtask

  // Starts at a negedge; returns at the negedge showing the eighth beat.
  task automatic run_line(int c, int inj_k, int other);
    start_i = 1; line_i = LW'(c);
    #1;
    chk(unit_en_o == N'(1 << (c % N)), "R5 start enable", unit_en_o, N'(1 << (c % N)));
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o == 1, "R2 busy rises", busy_o, 1);
    chk(unit_row_o[(c % N)*LW +: LW] == LW'(c), "R6 row aligned", unit_row_o[(c % N)*LW +: LW], c);
    chk(unit_en_o == N'(1 << ((c + 1) % N)), "R5 phase0 enable", unit_en_o, N'(1 << ((c + 1) % N)));
    for (int k = 0; k < N; k++) begin
      @(negedge clk_i);
      start_i = 0;
      chk(beat_valid_o == 1, "R2 beat valid", beat_valid_o, 1);
      chk(beat_data_o == pat(c, k), "R3 beat data", beat_data_o, pat(c, k));
      chk(busy_o == (k < N - 1), "R7 busy length", busy_o, (k < N - 1));
      if (k < N - 2) begin
        chk(unit_en_o == N'(1 << ((c + k + 2) % N)), "R4 lookahead enable", unit_en_o, N'(1 << ((c + k + 2) % N)));
        chk(unit_row_o[((c + k + 1) % N)*LW +: LW] == LW'(c), "R4 unit row",
            unit_row_o[((c + k + 1) % N)*LW +: LW], c);
      end else if (k == N - 2) begin
        chk(unit_en_o == 0, "R5 last phase no enable", unit_en_o, 0);
      end
      if (k == inj_k) begin
        start_i = 1; line_i = LW'(other);
        #1;
        chk(unit_en_o != N'(1 << (other % N)) || (other % N) == ((c + k + 2) % N),
            "R8 start ignored", unit_en_o, 0);
      end
    end
  endtask

  task automatic idle_after();
    @(negedge clk_i);
    chk(beat_valid_o == 0 && busy_o == 0, "R2 R8 idle after burst", {busy_o, beat_valid_o}, 0);
  endtask

  task automatic t_basic();       run_line(0, -1, 0); idle_after(); endtask
  task automatic t_mid();         run_line(5, -1, 0); idle_after(); endtask
  task automatic t_wrap();        run_line(63, -1, 0); idle_after(); endtask // R10
  task automatic t_busy_ignore(); run_line(12, 3, 40); idle_after(); endtask // R8
  task automatic t_chain();                                                  // R9
    run_line(9, -1, 0);
    run_line(58, -1, 0);
    idle_after();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_reset();
    fill();
    t_basic();
    t_mid();
    t_wrap();
    t_busy_ignore();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule